// File: doc/BRIEF.md
# Dual-Source Interrupt Level and Vector Unit

This block sits between two serial submodules, one SPI-type and one UART-type, and a host interrupt controller. Each source raises a request line, and software assigns each source a 3-bit priority level. The block picks one winner and presents it to the host as a single pending flag with a level. When the host acknowledges that level, the block answers with a vector byte. The upper seven bits of that byte come from a software-written vector base. The lowest bit is filled by hardware and names the winning source.

Software reaches the block through a 16-bit register word made of two byte lanes. The upper lane holds the two level fields, and the lower lane holds the vector base. A byte enable for each lane lets either one be written without touching the other. The source that owns the vector is captured at the first cycle of an acknowledge. Request changes later in that acknowledge cannot alter the byte being driven.

Top module: `irq_lvl_vec_unit`

## Requirements
- R1: A source whose level field is 0 never contributes a request. When no source is both enabled and requesting, `irqPending` is 0 and `irqLevel` is 0.
- R2: When both sources are enabled and requesting with different levels, `irqLevel` equals the higher of the two levels and `irqPending` is 1. With only one source active, `irqLevel` equals that source's level.
- R3: When both sources request with the same nonzero level, the SPI source wins, so an acknowledge of that level returns vector bit 0 = 1.
- R4: A write to the lower lane stores `regWrData[7:1]` as vector bits 7:1, and the value written to bit 0 is ignored. `regRdData[0]` always reads 1.
- R5: After reset, `regRdData` reads 0x000F: both levels are 0 and the vector is 0x0F. `irqPending` and `vecValid` are 0.
- R6: An acknowledge starts on the first clock edge at which `ackValid` is 1 after a cycle with it at 0. If at that edge `irqPending` is 1 and `ackLevel` equals `irqLevel`, then from the next cycle `vecValid` is 1 and `vecData` is {vector bits 7:1, source bit}, where the source bit is 1 for SPI and 0 for UART.
- R7: An acknowledge whose `ackLevel` differs from `irqLevel`, or that starts while nothing is pending, leaves `vecValid` at 0 and `vecData` at 0 for the whole acknowledge.
- R8: The source bit is captured only at the start of an acknowledge, and request changes during the acknowledge leave `vecData` unchanged. `vecValid` falls in the cycle after the first edge at which `ackValid` is 0.
- R9: `regByteEn[1]` writes the levels (SPI level at bits 14:12, UART level at bits 10:8), and `regByteEn[0]` writes the vector base. A lane whose enable is 0 keeps its value. The remaining bits of the word read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regByteEn | input | 2 | Lane enables: [1] levels, [0] vector |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data |
| spiReq | input | 1 | Request from the SPI-type source |
| uartReq | input | 1 | Request from the UART-type source |
| irqPending | output | 1 | A prioritized request is present |
| irqLevel | output | 3 | Level of the winning request |
| ackValid | input | 1 | Interrupt acknowledge in progress |
| ackLevel | input | 3 | Level being acknowledged |
| vecValid | output | 1 | The block is driving a vector |
| vecData | output | 8 | Vector byte, 0 when not driving |

## Verification
The acknowledge start can land in the same cycle as a register write that changes a level or the vector base. It can also land in the same cycle as a request edge on either source. The bench provokes both on purpose and then with random stimulus. The start decision must use the levels and requests seen at that edge, while the new register values take effect afterwards. A behavioural model updated on every clock judges `vecValid`, `vecData`, the pending flag and the read word against those rules in each cycle.

// File: rtl/irq_lvl_vec_pkg.sv
package irq_lvl_vec_pkg;
  // strobes from the control half to the datapath half
  typedef struct packed {
    logic wrLvl;    // load both level fields
    logic wrVec;    // load vector bits 7:1
    logic ackLoad;  // matching acknowledge started: capture source
    logic ackClear; // acknowledge ended: stop driving
    logic ackSpi;   // current winner is the SPI source
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_lvl_vec_ctrl.sv
module irq_lvl_vec_ctrl
  import irq_lvl_vec_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       byteEn,
  input  logic             spiReq,
  input  logic             uartReq,
  input  logic [LVL_W-1:0] spiLvl,
  input  logic [LVL_W-1:0] uartLvl,
  input  logic             ackValid,
  input  logic [LVL_W-1:0] ackLevel,
  output logic             irqPending,
  output logic [LVL_W-1:0] irqLevel,
  output ctrlStrobe_t      stb
);
  logic spiOn, uartOn, spiWins, ackActiveQ, ackStart;

  assign spiOn   = spiReq && (spiLvl != '0);
  assign uartOn  = uartReq && (uartLvl != '0);
  // on a tie the SPI source keeps the win
  assign spiWins = spiOn && (!uartOn || (spiLvl >= uartLvl));

  assign irqPending = spiOn || uartOn;
  always_comb begin
    if (spiWins)     irqLevel = spiLvl;
    else if (uartOn) irqLevel = uartLvl;
    else             irqLevel = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackActiveQ <= 1'b0;
    else       ackActiveQ <= ackValid;
  end

  assign ackStart = ackValid && !ackActiveQ;

  always_comb begin
    stb.wrLvl    = wrEn && byteEn[1];
    stb.wrVec    = wrEn && byteEn[0];
    stb.ackLoad  = ackStart && irqPending && (ackLevel == irqLevel);
    stb.ackClear = !ackValid;
    stb.ackSpi   = spiWins;
  end

  // R1: nothing pending means a zero level
  p_idle_level_r1: assert property (@(posedge clk) disable iff (!rstN)
    !irqPending |-> (irqLevel == '0));

  // R2: the level shown is never below any active source
  p_level_max_r2: assert property (@(posedge clk) disable iff (!rstN)
    irqPending |-> ((irqLevel >= (spiOn ? spiLvl : '0)) &&
                    (irqLevel >= (uartOn ? uartLvl : '0))));

  // R8: one capture per acknowledge
  p_single_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.ackLoad |=> !stb.ackLoad);
endmodule

// File: rtl/irq_lvl_vec_dp.sv
module irq_lvl_vec_dp
  import irq_lvl_vec_pkg::*;
#(
  parameter int          LVL_W   = 3,
  parameter int          VEC_W   = 8,
  parameter logic [7:0]  VEC_RST = 8'h0F
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        stb,
  input  logic [2*VEC_W-1:0] wrData,
  output logic [2*VEC_W-1:0] rdData,
  output logic [LVL_W-1:0]   spiLvl,
  output logic [LVL_W-1:0]   uartLvl,
  output logic               vecValid,
  output logic [VEC_W-1:0]   vecData
);
  localparam int DATA_W   = 2 * VEC_W;
  localparam int UART_LSB = VEC_W;
  localparam int SPI_LSB  = VEC_W + VEC_W / 2;
  localparam logic [VEC_W-1:0] RST_VEC = VEC_W'(VEC_RST);

  logic [LVL_W-1:0] spiLvlQ, uartLvlQ;
  logic [VEC_W-2:0] vecHiQ;
  logic             ackHitQ, ackSpiQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spiLvlQ  <= '0;
      uartLvlQ <= '0;
      vecHiQ   <= RST_VEC[VEC_W-1:1];
      ackHitQ  <= 1'b0;
      ackSpiQ  <= 1'b0;
    end else begin
      if (stb.wrLvl) begin
        spiLvlQ  <= wrData[SPI_LSB +: LVL_W];
        uartLvlQ <= wrData[UART_LSB +: LVL_W];
      end
      if (stb.wrVec) vecHiQ <= wrData[VEC_W-1:1];
      if (stb.ackClear) begin
        ackHitQ <= 1'b0;
      end else if (stb.ackLoad) begin
        ackHitQ <= 1'b1;
        ackSpiQ <= stb.ackSpi;
      end
    end
  end

  always_comb begin
    rdData                      = '0;
    rdData[SPI_LSB +: LVL_W]    = spiLvlQ;
    rdData[UART_LSB +: LVL_W]   = uartLvlQ;
    rdData[VEC_W-1:1]           = vecHiQ;
    rdData[0]                   = 1'b1;
  end

  assign spiLvl   = spiLvlQ;
  assign uartLvl  = uartLvlQ;
  assign vecValid = ackHitQ;
  assign vecData  = ackHitQ ? {vecHiQ, ackSpiQ} : '0;

  // R4: bit 0 of the read word is always set
  p_rd_lsb_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdData[0] == 1'b1);

  // R8: the source bit holds through a driven acknowledge
  p_src_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (vecValid && $past(vecValid)) |-> (vecData[0] == $past(vecData[0])));

  // R7: silent means all zero
  p_silent_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    !vecValid |-> (vecData == '0));

  initial begin
    assert (DATA_W >= SPI_LSB + LVL_W) else $error("level field does not fit");
  end
endmodule

// File: rtl/irq_lvl_vec_unit.sv
module irq_lvl_vec_unit
  import irq_lvl_vec_pkg::*;
#(
  parameter int         LVL_W   = 3,
  parameter int         VEC_W   = 8,
  parameter logic [7:0] VEC_RST = 8'h0F
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [1:0]         regByteEn,
  input  logic [2*VEC_W-1:0] regWrData,
  output logic [2*VEC_W-1:0] regRdData,
  input  logic               spiReq,
  input  logic               uartReq,
  output logic               irqPending,
  output logic [LVL_W-1:0]   irqLevel,
  input  logic               ackValid,
  input  logic [LVL_W-1:0]   ackLevel,
  output logic               vecValid,
  output logic [VEC_W-1:0]   vecData
);
  ctrlStrobe_t      stb;
  logic [LVL_W-1:0] spiLvl, uartLvl;

  irq_lvl_vec_ctrl #(.LVL_W(LVL_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .byteEn(regByteEn),
    .spiReq(spiReq), .uartReq(uartReq), .spiLvl(spiLvl), .uartLvl(uartLvl),
    .ackValid(ackValid), .ackLevel(ackLevel),
    .irqPending(irqPending), .irqLevel(irqLevel), .stb(stb)
  );

  irq_lvl_vec_dp #(.LVL_W(LVL_W), .VEC_W(VEC_W), .VEC_RST(VEC_RST)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWrData), .rdData(regRdData),
    .spiLvl(spiLvl), .uartLvl(uartLvl), .vecValid(vecValid), .vecData(vecData)
  );

  // R6: a vector is only driven inside an acknowledge
  p_vec_in_ack_r6: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> $past(ackValid));
endmodule

// File: tb/irq_lvl_vec_unit_tb.sv
module irq_lvl_vec_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regByteEn = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        spiReq = 1'b0, uartReq = 1'b0;
  logic        irqPending;
  logic [2:0]  irqLevel;
  logic        ackValid = 1'b0;
  logic [2:0]  ackLevel = '0;
  logic        vecValid;
  logic [7:0]  vecData;

  int testsRun = 0;
  int testsFailed = 0;
  bit modelOn = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_lvl_vec_unit dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regByteEn(regByteEn),
    .regWrData(regWrData), .regRdData(regRdData), .spiReq(spiReq),
    .uartReq(uartReq), .irqPending(irqPending), .irqLevel(irqLevel),
    .ackValid(ackValid), .ackLevel(ackLevel), .vecValid(vecValid),
    .vecData(vecData)
  );

  // behavioural reference state
  int  mSpi, mUart, mVec;  // mVec holds the full byte with bit 0 forced
  bit  mPrevAck, mHit, mSrc;

  function automatic bit spiActive();  return spiReq && mSpi != 0;  endfunction
  function automatic bit uartActive(); return uartReq && mUart != 0; endfunction
  function automatic int expLevel();
    int a = spiActive() ? mSpi : 0;
    int b = uartActive() ? mUart : 0;
    return (a > b) ? a : b;
  endfunction
  function automatic bit expSpiWin();
    return spiActive() && (!uartActive() || mSpi >= mUart);
  endfunction
  function automatic int expRead();
    return (mSpi << 12) | (mUart << 8) | mVec;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSpi <= 0; mUart <= 0; mVec <= 8'h0F; mPrevAck <= 0; mHit <= 0; mSrc <= 0;
    end else begin
      if (regWrEn && regByteEn[1]) begin
        mSpi <= int'(regWrData[14:12]); mUart <= int'(regWrData[10:8]);
      end
      if (regWrEn && regByteEn[0]) mVec <= int'(regWrData[7:0]) | 1;
      mPrevAck <= ackValid;
      if (!ackValid) mHit <= 0;
      else if (!mPrevAck && (expLevel() != 0) && (int'(ackLevel) == expLevel())) begin
        mHit <= 1; mSrc <= expSpiWin();
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && modelOn) begin
      check("R9 read word", int'(regRdData), expRead());
      check("R1 pending", int'(irqPending), int'(expLevel() != 0));
      check("R2 level", int'(irqLevel), expLevel());
      check("R6 vecValid", int'(vecValid), int'(mHit));
      check("R6 vecData", int'(vecData), mHit ? ((mVec & 8'hFE) | int'(mSrc)) : 0);
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic waitNeg(); @(negedge clk); endtask

  task automatic regWrite(logic [1:0] be, logic [15:0] d);
    regWrEn = 1'b1; regByteEn = be; regWrData = d;
    tick();
    regWrEn = 1'b0; regByteEn = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    testsFailed++;
    $display("FAIL watchdog all R5 actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    modelOn = 1;
    waitNeg();
    // R5 reset state
    check("R5 reset read", int'(regRdData), 16'h000F);
    check("R5 reset pending", int'(irqPending), 0);
    check("R5 reset vecValid", int'(vecValid), 0);

    // R1 requests with both levels zero
    tick(); spiReq = 1; uartReq = 1;
    waitNeg();
    check("R1 disabled pending", int'(irqPending), 0);
    check("R1 disabled level", int'(irqLevel), 0);

    // R9 level lane only
    tick(); regWrite(2'b10, 16'h35FF);
    waitNeg();
    check("R9 level lane", int'(regRdData), 16'h350F);
    check("R2 higher level", int'(irqLevel), 5);

    // R4 vector lane, bit 0 write ignored
    tick(); regWrite(2'b01, 16'h77A0);
    waitNeg();
    check("R4 vector write", int'(regRdData), 16'h35A1);

    // R6 acknowledge of the UART level
    tick(); ackLevel = 3'd5; ackValid = 1;
    tick(); uartReq = 0;        // R8 request drops mid-acknowledge
    waitNeg();
    check("R6 uart vector", int'(vecData), 8'hA0);
    check("R6 vecValid", int'(vecValid), 1);
    tick();
    waitNeg();
    check("R8 held vector", int'(vecData), 8'hA0);
    tick(); ackValid = 0;
    tick();
    waitNeg();
    check("R8 release", int'(vecValid), 0);

    // R3 tie at level 4
    tick(); uartReq = 1; regWrite(2'b10, 16'h4400);
    ackLevel = 3'd4; ackValid = 1;
    tick();
    waitNeg();
    check("R3 tie spi vector", int'(vecData), 8'hA1);
    tick(); ackValid = 0;
    tick();

    // R7 mismatched level
    ackLevel = 3'd2; ackValid = 1;
    tick(); tick();
    waitNeg();
    check("R7 mismatch valid", int'(vecValid), 0);
    check("R7 mismatch data", int'(vecData), 0);
    tick(); ackValid = 0;

    // acknowledge start together with a level write
    tick(); ackLevel = 3'd4; ackValid = 1;
    regWrite(2'b10, 16'h2600);
    waitNeg();
    check("R6 start uses old level", int'(vecData), 8'hA1);
    tick(); ackValid = 0; tick();

    // random phase, judged by the model
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      spiReq    = r[0];
      uartReq   = r[1];
      ackValid  = r[2] | (r[3] & ackValid);
      ackLevel  = r[6:4];
      regWrEn   = (r[10:7] == 4'd0);
      regByteEn = r[12:11];
      regWrData = r[31:16];
      tick();
    end
    regWrEn = 0; ackValid = 0;
    tick(); waitNeg();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule